// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits out a power-up pause, then issues a burst of refresh cycles of the CAS-before-RAS kind, and only then raises its ready flag. From that point a free-running interval timer owes one refresh per interval. Each owed refresh is added to a backlog counter, and cycles are issued until the backlog is empty. Every refresh cycle holds WE high, because a CAS-before-RAS cycle with WE low would put the memory into a test mode.

The RAS, CAS and WE pins are shared with a main memory controller. The sequencer raises `req` and drives the pins only while `gnt` is returned, signalling ownership on `drive_en`. If the grant is withheld for so long that the backlog reaches its limit and one more interval expires, the refresh deadline is treated as missed. The block then drops `ready` and reruns the whole wake-up burst, without the initial pause. All timings are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ready`, `req` and `drive_en` are 0, and `ras_n`, `cas_n` and `we_n` are 1.
- R2: `req` first rises exactly `T_PAUSE` clock cycles after reset is released, and no pin is driven before then.
- R3: After the pause, exactly `N_WAKE` refresh cycles (RAS falling edges) are issued before `ready` rises.
- R4: In each refresh cycle, CAS is low for exactly `T_CSR` cycles before RAS falls, and stays low for exactly `T_CHR` cycles of the RAS-low time.
- R5: `we_n` is 1 in every cycle in which `drive_en` is 1.
- R6: RAS stays low for exactly `T_RAS` cycles per refresh, and it is high for at least `T_RP` cycles before each falling edge.
- R7: Once raised, `req` stays high until `gnt` is seen. The pins are driven (`drive_en` = 1) only while `gnt` is 1.
- R8: While `ready` is 1 and grants are given, one refresh is issued for each `T_INTERVAL` cycles elapsed.
- R9: Intervals that expire while the grant is withheld accumulate. When the grant returns, that many refresh cycles are issued back to back, and `req` then falls.
- R10: If an interval expires while the backlog already holds `MAX_PEND` refreshes, `ready` falls in that cycle, which is `MAX_PEND*T_INTERVAL` cycles after the first withheld request. The sequencer then issues `N_WAKE` refresh cycles and raises `ready` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gnt | input | 1 | Pin ownership granted by the main controller |
| req | output | 1 | Request for pin ownership |
| drive_en | output | 1 | Sequencer is driving RAS/CAS/WE |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high for refresh |
| ready | output | 1 | Memory has been woken and is being refreshed |

## Verification
The bench goes after the exact length of the power-up pause and the exact wake-up count. A design that counted one cycle too few would either release the pins early or declare the memory ready before its eighth cycle. It withholds the grant across two intervals and then releases it, to catch a backlog that drops or duplicates owed refreshes. It also withholds the grant past the limit and measures the cycle in which `ready` falls, along with the count of the rerun burst. A design with an off-by-one limit, or one that forgot to rerun the wake-up, shows up there. Every strobe edge is timed against the CAS lead, CAS hold, RAS width and precharge figures, under a random grant latency.

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int T_PAUSE    = 5000,
  parameter int N_WAKE     = 8,
  parameter int T_INTERVAL = 780,
  parameter int MAX_PEND   = 8,
  parameter int T_RP       = 3,
  parameter int T_CSR      = 1,
  parameter int T_CHR      = 1,
  parameter int T_RAS      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  output logic req,
  output logic drive_en,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int PW  = $clog2(T_PAUSE + 1);
  localparam int HW  = $clog2(T_RP + T_CSR + T_RAS + 1);
  localparam int TW  = $clog2(T_INTERVAL + 1);
  localparam int QW  = $clog2(MAX_PEND + 1);
  localparam int WW  = $clog2(N_WAKE + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(T_PAUSE - 1);
  localparam logic [HW-1:0] RP_LAST    = HW'(T_RP - 1);
  localparam logic [HW-1:0] CSR_LAST   = HW'(T_CSR - 1);
  localparam logic [HW-1:0] RAS_LAST   = HW'(T_RAS - 1);
  localparam logic [HW-1:0] CHR_LIM    = HW'(T_CHR);
  localparam logic [TW-1:0] INT_LAST   = TW'(T_INTERVAL - 1);
  localparam logic [QW-1:0] PEND_FULL  = QW'(MAX_PEND);
  localparam logic [WW-1:0] WAKE_ALL   = WW'(N_WAKE);

  typedef enum logic [2:0] {ST_PAUSE, ST_IDLE, ST_PRE, ST_CSR, ST_RAS} st_t;

  st_t           st;
  logic [PW-1:0] pcnt;
  logic [HW-1:0] ph;
  logic [TW-1:0] tcnt;
  logic [QW-1:0] pend;
  logic [WW-1:0] wake;

  wire need = (wake != '0) || (pend != '0);
  wire done = (st == ST_RAS) && (ph == RAS_LAST);
  wire tick = ready && (tcnt == INT_LAST);
  wire miss = tick && (pend == PEND_FULL);

  assign drive_en = (st == ST_PRE) || (st == ST_CSR) || (st == ST_RAS);
  assign req      = drive_en || ((st == ST_IDLE) && need);
  assign ras_n    = (st != ST_RAS);
  assign cas_n    = !((st == ST_CSR) || ((st == ST_RAS) && (ph < CHR_LIM)));
  assign we_n     = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_PAUSE;
      pcnt  <= '0;
      ph    <= '0;
      tcnt  <= '0;
      pend  <= '0;
      wake  <= '0;
      ready <= 1'b0;
    end else begin
      unique case (st)
        ST_PAUSE: if (pcnt == PAUSE_LAST) begin
                    st   <= ST_IDLE;
                    wake <= WAKE_ALL;
                  end else pcnt <= pcnt + 1'b1;
        ST_IDLE:  if (need && gnt) begin st <= ST_PRE; ph <= '0; end
        ST_PRE:   if (ph == RP_LAST)  begin st <= ST_CSR; ph <= '0; end else ph <= ph + 1'b1;
        ST_CSR:   if (ph == CSR_LAST) begin st <= ST_RAS; ph <= '0; end else ph <= ph + 1'b1;
        ST_RAS:   if (done)           begin st <= ST_IDLE; ph <= '0; end else ph <= ph + 1'b1;
        default:  st <= ST_IDLE;
      endcase

      if (miss) begin
        ready <= 1'b0;
        wake  <= WAKE_ALL;
        pend  <= '0;
        tcnt  <= '0;
      end else if (done && wake != '0) begin
        wake <= wake - 1'b1;
        if (wake == WW'(1)) begin
          ready <= 1'b1;
          tcnt  <= '0;
          pend  <= '0;
        end
      end else if (ready) begin
        tcnt <= tick ? '0 : tcnt + 1'b1;
        case ({tick, done})
          2'b10:   pend <= pend + 1'b1;
          2'b01:   pend <= pend - 1'b1;
          default: pend <= pend;
        endcase
      end
    end
  end
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int N_WAKE = 8,
  parameter int T_RP   = 3,
  parameter int T_RAS  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic gnt,
  input logic req,
  input logic drive_en,
  input logic ras_n,
  input logic cas_n,
  input logic ready
);
  int unsigned lo_cnt, hi_cnt, wake_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt    <= 0;
      hi_cnt    <= 0;
      wake_seen <= 0;
    end else begin
      lo_cnt <= ras_n ? 0 : lo_cnt + 1;
      hi_cnt <= !ras_n ? 0 : (hi_cnt < 1000000 ? hi_cnt + 1 : hi_cnt);
      if (ready) wake_seen <= 0;
      else if ($fell(ras_n)) wake_seen <= wake_seen + 1;
    end
  end

  AST_CAS_LEADS:   assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> (!cas_n && !$past(cas_n))); // R4
  AST_RAS_WIDTH:   assert property (@(posedge clk) disable iff (!rst_n) $rose(ras_n) |-> (lo_cnt >= T_RAS));        // R6
  AST_PRECHARGE:   assert property (@(posedge clk) disable iff (!rst_n) $fell(ras_n) |-> (hi_cnt >= T_RP));         // R6
  AST_PINS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n) drive_en |-> gnt);                         // R7
  AST_REQ_HELD:    assert property (@(posedge clk) disable iff (!rst_n) (req && !gnt) |=> req);                     // R7
  AST_WAKE_COUNT:  assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> (wake_seen == N_WAKE));    // R3
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.N_WAKE(N_WAKE), .T_RP(T_RP), .T_RAS(T_RAS)) u_chk (.*);

// File: tb/dram_refresh_seq_tb.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb;
  localparam int T_PAUSE = 50, N_WAKE = 8, T_INTERVAL = 40, MAX_PEND = 3;
  localparam int T_RP = 3, T_CSR = 2, T_CHR = 2, T_RAS = 4;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  logic req, drive_en, ras_n, cas_n, we_n, ready;
  bit   hold_off = 1'b0;
  int   vecs = 0, errs = 0, falls = 0;

  always #10 clk = ~clk;

  dram_refresh_seq #(.T_PAUSE(T_PAUSE), .N_WAKE(N_WAKE), .T_INTERVAL(T_INTERVAL),
    .MAX_PEND(MAX_PEND), .T_RP(T_RP), .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS)) u_dut (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req), .drive_en(drive_en),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int rp_ok(input int hi); return (hi >= T_RP) ? 1 : 0; endfunction

  // grant driver: random latency, forced off while hold_off
  initial begin
    int lat = 0;
    void'($urandom(32'd5150));
    forever begin
      @(negedge clk);
      if (!rst_n || hold_off) gnt = 1'b0;
      else if (!req) begin gnt = 1'b0; lat = $urandom % 4; end
      else if (!gnt) begin if (lat == 0) gnt = 1'b1; else lat--; end
    end
  end

  // strobe monitor: R4 R5 R6 R7
  int lead = 0, lo = 0, hi = 0, hold = 0;
  bit prev_ras = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1; lead = 0; lo = 0; hi = 0; hold = 0;
    end else begin
      if (drive_en) begin
        chk(we_n == 1'b1, "R5 we_n while driving", we_n, 1);
        chk(gnt == 1'b1, "R7 drive without grant", gnt, 1);
      end
      if (prev_ras && !ras_n) begin
        falls++;
        chk(lead == T_CSR, "R4 CAS lead", lead, T_CSR);
        chk(rp_ok(hi) == 1, "R6 precharge", hi, T_RP);
        lo = 0; hold = 0;
      end
      if (!prev_ras && ras_n) begin
        chk(lo == T_RAS, "R6 RAS width", lo, T_RAS);
        chk(hold == T_CHR, "R4 CAS hold", hold, T_CHR);
        hi = 0; lead = 0;
      end
      if (!ras_n) begin lo++; if (!cas_n) hold++; end
      else begin hi++; if (!cas_n) lead++; else lead = 0; end
      prev_ras = ras_n;
    end
  end

  initial begin
    #(20 * 100000);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int c, f0;
    repeat (3) @(negedge clk);
    chk(ready == 0, "R1 ready", ready, 0);
    chk(req == 0, "R1 req", req, 0);
    chk(drive_en == 0, "R1 drive_en", drive_en, 0);
    chk(ras_n && cas_n && we_n, "R1 strobes idle", {ras_n, cas_n, we_n}, 7);
    rst_n = 1'b1;

    c = 0;
    do begin @(posedge clk); c++; @(negedge clk); end while (!req && c < T_PAUSE + 10);
    chk(c == T_PAUSE, "R2 pause length", c, T_PAUSE);

    c = 0;
    while (!ready && c < 2000) begin @(negedge clk); c++; end
    chk(ready == 1, "R3 ready after wake", ready, 1);
    chk(falls == N_WAKE, "R3 wake count", falls, N_WAKE);

    f0 = falls;
    repeat (10 * T_INTERVAL + 20) @(negedge clk);
    chk(falls - f0 == 10, "R8 steady rate", falls - f0, 10);
    chk(ready == 1, "R8 ready held", ready, 1);

    // R9: two intervals owed while grant withheld
    while (req) @(negedge clk);
    hold_off = 1'b1;
    while (!req) @(negedge clk);
    repeat (T_INTERVAL + 5) @(negedge clk);
    chk(falls == f0 + 10, "R9 no cycle while withheld", falls - f0, 10);
    f0 = falls;
    hold_off = 1'b0;
    c = 0;
    while (req && c < 200) begin @(negedge clk); c++; end
    chk(falls - f0 == 2, "R9 backlog drained", falls - f0, 2);
    chk(req == 0, "R9 req released", req, 0);

    // R10: deadline missed
    while (req) @(negedge clk);
    hold_off = 1'b1;
    while (!req) @(negedge clk);
    c = 0;
    do begin @(posedge clk); c++; @(negedge clk); end while (ready && c < (MAX_PEND + 3) * T_INTERVAL);
    chk(c == MAX_PEND * T_INTERVAL, "R10 miss cycle", c, MAX_PEND * T_INTERVAL);
    chk(ready == 0, "R10 ready dropped", ready, 0);
    f0 = falls;
    repeat ($urandom % 7) @(negedge clk);
    hold_off = 1'b0;
    c = 0;
    while (!ready && c < 2000) begin @(negedge clk); c++; end
    chk(falls - f0 == N_WAKE, "R10 rerun count", falls - f0, N_WAKE);
    chk(ready == 1, "R10 ready again", ready, 1);

    repeat (4 * T_INTERVAL) @(negedge clk);
    chk(ready == 1, "R8 ready after rerun", ready, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule